// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of a fractional-N frequency synthesizer. It counts cycles of the fast oscillator clock and emits a single-cycle pulse when each division period ends. Each period lasts either the integer base count or one count more. The choice comes from a fractional accumulator with a programmable numerator and an arbitrary, non-power-of-two denominator. Over time, the average division ratio equals the base plus numerator over denominator.

A new setting (base, numerator, denominator) is offered with a one-cycle load strobe. A setting that passes the legality check is held as pending. It replaces the running setting at the next period boundary, and at that boundary the accumulator and the carry are cleared. An illegal setting is dropped and the running one continues. All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `frac_n_divider`

## Requirements
- R1: `div_pulse` is high for exactly one clock at the end of each period. The number of clocks from one pulse to the next equals that period's modulus.
- R2: At every period boundary the accumulator adds NUM. If the sum is DEN or more, DEN is subtracted and a carry is produced; otherwise the carry is 0. `acc_state` is always below DEN.
- R3: A carry produced at a boundary makes the period that starts there last N_int+1 clocks; without a carry the period lasts N_int clocks. `carry_out` is 1 exactly during the periods of length N_int+1.
- R4: Take any DEN consecutive periods that begin one period after a setting takes effect. Together they last DEN*N_int + NUM clocks.
- R5: With N_int=8 and NUM/DEN = 1/5, the periods after the first post-load period repeat the lengths 8,8,8,8,9. The matching `acc_state` values are 1,2,3,4,0 and the carry pattern is 0,0,0,0,1.
- R6: With NUM=0 every period lasts exactly N_int clocks and `carry_out` stays 0.
- R7: DEN may be any value from 1 to 2^22-1, and is not limited to a power of two. A denominator of 1968 gives exact averaging.
- R8: A load strobe never changes the period in progress. An accepted setting takes effect at the next period boundary.
- R9: When a setting takes effect, `acc_state` and `carry_out` become 0. The first new period lasts exactly the new N_int.
- R10: A load with N_int below 3, or with NUM not below DEN, is rejected and the running setting is kept.
- R11: After reset `acc_state` is 0, `carry_out` is 0, NUM is 0 and DEN is 1. The period is the `NINT_RESET` parameter, which defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that offers a new setting |
| cfg_nint | input | 16 | Integer base of the division ratio |
| cfg_num | input | 22 | Fraction numerator |
| cfg_den | input | 22 | Fraction denominator |
| div_pulse | output | 1 | One-clock pulse at the end of each period |
| carry_out | output | 1 | High during periods that divide by N_int+1 |
| acc_state | output | 22 | Accumulator value for the current period |

## Verification
The in-line assertions check, on every cycle, these structural rules:
- the output pulse is one cycle wide;
- the accumulator stays below the denominator;
- the carry and the running setting change only at period boundaries;
- a newly applied setting starts from a cleared accumulator;
- no illegal setting ever becomes the running one.

Only the bench's scenarios can show the arithmetic over time. These are the exact clock totals over whole denominator windows (including a 1968 denominator), the 1/5 carry pattern, and the period lengths around a mid-period load. They also include the rejected loads, observed as unchanged period lengths at the output.

// File: rtl/fnd_pkg.sv
`timescale 1ns/1ps
package fnd_pkg;
  localparam int NINT_W   = 16;
  localparam int FRAC_W   = 22;
  localparam int NINT_MIN = 3;

  typedef struct packed {
    logic [NINT_W-1:0] nint;
    logic [FRAC_W-1:0] num;
    logic [FRAC_W-1:0] den;
  } fnd_cfg_t;
endpackage

// File: rtl/fnd_cfg_stage.sv
`timescale 1ns/1ps
module fnd_cfg_stage
  import fnd_pkg::*;
#(
  parameter logic [NINT_W-1:0] NINT_RESET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  fnd_cfg_t          req_i,
  input  logic              boundary_i,
  output fnd_cfg_t          act_o,
  output logic [NINT_W-1:0] nxt_nint_o,
  output logic              apply_o
);
  fnd_cfg_t pend_q;
  logic     pend_vld_q;
  logic     accept;

  assign accept = load_i && (req_i.nint >= NINT_W'(NINT_MIN)) && (req_i.num < req_i.den);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_o      <= '{nint: NINT_RESET, num: '0, den: FRAC_W'(1)};
    end else begin
      if (accept) begin
        pend_q     <= req_i;
        pend_vld_q <= 1'b1;
      end else if (boundary_i) begin
        pend_vld_q <= 1'b0;
      end
      if (boundary_i && pend_vld_q) act_o <= pend_q;
    end
  end

  assign apply_o    = boundary_i && pend_vld_q;
  assign nxt_nint_o = pend_vld_q ? pend_q.nint : act_o.nint;

  AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(act_o)); // R8
  AST_NINT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    act_o.nint >= NINT_W'(NINT_MIN)); // R10
  AST_FRACTION_PROPER: assert property (@(posedge clk) disable iff (!rst_n)
    act_o.num < act_o.den); // R10
endmodule

// File: rtl/fnd_frac_acc.sv
`timescale 1ns/1ps
module fnd_frac_acc
  import fnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              carry_o,
  output logic              carry_nxt_o
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_nxt;

  always_comb begin
    sum         = {1'b0, acc_o} + {1'b0, num_i};
    carry_nxt_o = (sum >= {1'b0, den_i});
    acc_nxt     = FRAC_W'(carry_nxt_o ? (sum - {1'b0, den_i}) : sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      acc_o   <= '0;
      carry_o <= 1'b0;
    end else if (step_i) begin
      acc_o   <= acc_nxt;
      carry_o <= carry_nxt_o;
    end
  end

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o < den_i); // R2
  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(carry_o)); // R3
  AST_CLEAR_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_o == '0) && !carry_o); // R9
endmodule

// File: rtl/fnd_mod_counter.sv
`timescale 1ns/1ps
module fnd_mod_counter
  import fnd_pkg::*;
#(
  parameter logic [NINT_W-1:0] NINT_RESET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NINT_W-1:0] nxt_nint_i,
  input  logic              add_one_i,
  output logic              pulse_o
);
  localparam int CNT_W = NINT_W + 1;
  logic [CNT_W-1:0] cnt_q;

  assign pulse_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= CNT_W'(NINT_RESET) - CNT_W'(1);
    else if (pulse_o)
      cnt_q <= {1'b0, nxt_nint_i} + CNT_W'(add_one_i) - CNT_W'(1);
    else
      cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_o |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R1
endmodule

// File: rtl/frac_n_divider.sv
`timescale 1ns/1ps
module frac_n_divider
  import fnd_pkg::*;
#(
  parameter logic [NINT_W-1:0] NINT_RESET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [NINT_W-1:0] cfg_nint,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              div_pulse,
  output logic              carry_out,
  output logic [FRAC_W-1:0] acc_state
);
  fnd_cfg_t          req, act;
  logic [NINT_W-1:0] nxt_nint;
  logic              apply, carry_nxt;

  assign req = '{nint: cfg_nint, num: cfg_num, den: cfg_den};

  fnd_cfg_stage #(.NINT_RESET(NINT_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .req_i(req),
    .boundary_i(div_pulse), .act_o(act), .nxt_nint_o(nxt_nint), .apply_o(apply)
  );

  fnd_frac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .step_i(div_pulse), .clear_i(apply),
    .num_i(act.num), .den_i(act.den), .acc_o(acc_state),
    .carry_o(carry_out), .carry_nxt_o(carry_nxt)
  );

  fnd_mod_counter #(.NINT_RESET(NINT_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .nxt_nint_i(nxt_nint),
    .add_one_i(carry_nxt && !apply), .pulse_o(div_pulse)
  );
endmodule

// File: tb/tb_frac_n_divider.sv
`timescale 1ns/1ps
module tb_frac_n_divider;
  import fnd_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_load = 1'b0;
  logic [NINT_W-1:0] cfg_nint = '0;
  logic [FRAC_W-1:0] cfg_num = '0;
  logic [FRAC_W-1:0] cfg_den = '0;
  logic              div_pulse, carry_out;
  logic [FRAC_W-1:0] acc_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  frac_n_divider dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_nint(cfg_nint),
    .cfg_num(cfg_num), .cfg_den(cfg_den), .div_pulse(div_pulse),
    .carry_out(carry_out), .acc_state(acc_state)
  );

  always #2.5 clk = ~clk;

  localparam int NV = 6;
  localparam int V_NINT[NV] = '{8, 3, 10, 4, 17, 5};
  localparam int V_NUM [NV] = '{1, 2, 0, 7, 3, 1967};
  localparam int V_DEN [NV] = '{5, 7, 13, 1968, 4, 1968};
  localparam int V_REP [NV] = '{2, 2, 1, 1, 3, 1};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!div_pulse);
  endtask

  task automatic load(input int n, input int nu, input int d);
    cfg_nint = NINT_W'(n); cfg_num = FRAC_W'(nu); cfg_den = FRAC_W'(d);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // after load, reach the negedge where the applying pulse is visible
  task automatic to_apply();
    int l;
    if (!div_pulse) next_pulse(l);
  endtask

  // first period after applying: checks R9, returns length
  task automatic first_period(input int n);
    int len;
    @(negedge clk);
    chk(acc_state == 0 && carry_out == 1'b0, "R9 cleared state", acc_state, 0);
    len = 1;
    while (!div_pulse) begin @(negedge clk); len++; end
    chk(len == n, "R9 first period length", len, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int len, tot, bad_len, bad_car, bad_acc, nlong;
    // reset state, R11
    repeat (3) @(negedge clk);
    chk(acc_state == 0, "R11 acc after reset", acc_state, 0);
    chk(carry_out == 0, "R11 carry after reset", carry_out, 0);
    rst_n = 1'b1;
    next_pulse(len);
    next_pulse(len);
    chk(len == 8, "R11 R1 reset period", len, 8);

    // vector table: R2 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      load(V_NINT[v], V_NUM[v], V_DEN[v]);
      to_apply();
      first_period(V_NINT[v]);
      tot = 0; bad_len = 0; bad_car = 0; bad_acc = 0; nlong = 0;
      for (int p = 0; p < V_REP[v] * V_DEN[v]; p++) begin
        next_pulse(len);
        tot += len;
        if (len != V_NINT[v] && len != V_NINT[v] + 1) bad_len++;
        if (carry_out != (len == V_NINT[v] + 1)) bad_car++;
        if (acc_state >= FRAC_W'(V_DEN[v])) bad_acc++;
        if (len == V_NINT[v] + 1) nlong++;
      end
      chk(tot == V_REP[v] * (V_DEN[v] * V_NINT[v] + V_NUM[v]), "R4 R7 window total",
          tot, V_REP[v] * (V_DEN[v] * V_NINT[v] + V_NUM[v]));
      chk(bad_len == 0, "R1 period length set", bad_len, 0);
      chk(bad_car == 0, "R3 carry marks long period", bad_car, 0);
      chk(bad_acc == 0, "R2 acc below den", bad_acc, 0);
      if (V_NUM[v] == 0) chk(nlong == 0, "R6 integer divide", nlong, 0);
    end

    // R5: 1/5 pattern
    load(8, 1, 5);
    to_apply();
    first_period(8);
    for (int p = 0; p < 5; p++) begin
      next_pulse(len);
      chk(len == ((p == 4) ? 9 : 8), "R5 length pattern", len, (p == 4) ? 9 : 8);
      chk(acc_state == FRAC_W'((p + 1) % 5), "R5 acc pattern", acc_state, (p + 1) % 5);
      chk(carry_out == (p == 4), "R5 carry pattern", carry_out, p == 4);
    end

    // R8: mid-period load does not disturb the running period
    load(7, 0, 1);
    to_apply();
    first_period(7);
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (len == 2) begin
        cfg_nint = 12; cfg_num = 0; cfg_den = 1; cfg_load = 1'b1;
      end else cfg_load = 1'b0;
    end while (!div_pulse);
    cfg_load = 1'b0;
    chk(len == 7, "R8 running period kept", len, 7);
    first_period(12);

    // R10: rejected loads keep the 12 setting
    load(2, 0, 1);
    next_pulse(len); next_pulse(len);
    chk(len == 12, "R10 small nint rejected", len, 12);
    load(9, 5, 5);
    next_pulse(len); next_pulse(len);
    chk(len == 12 && carry_out == 0, "R10 num>=den rejected", len, 12);
    load(0, 0, 0);
    next_pulse(len); next_pulse(len);
    chk(len == 12, "R10 zero setting rejected", len, 12);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule